// File: doc/BRIEF.md
# T1 Frame Sync Supervisor

This block decides whether a T1 receiver is in frame. An upstream aligner reports one result per received framing bit: whether the bit matched the expected pattern and, in superframe (D4) mode, whether it was a terminal-framing (Ft) or signalling-framing (Fs) position. The supervisor qualifies a candidate alignment over a selectable run of good framing bits, then watches a sliding error window. It declares out-of-frame when two errors fall within the last four, five or six framing bits.

When it drops out of frame, or the receive carrier is lost, it can restart the search on its own. The search can also be restarted by a rising edge on a control input. The start of every new search is signalled to the aligner with a one-clock request. In extended superframe (ESF) mode, sync can optionally wait for a passing CRC6 result before it is declared.

Top module: `t1_sync_supervisor`

## Requirements
- R1: After reset `in_sync_o` and `search_req_o` are 0 and the block is qualifying.
- R2: In the cross-coupled setting, `in_sync_o` becomes 1 on the clock after the qualifying run completes. The run is 10 consecutive good framing bits with `sync_long_i`=0 and 24 with `sync_long_i`=1. One fewer is not enough.
- R3: A framing error that counts toward qualification pulses `search_req_o` for exactly one clock and restarts the qualifying count from zero.
- R4: In D4 mode with `sync_crit_i`=0, qualification is sequential. First a full run of Ft bits (`fbit_ft_i`=1) is counted, then a full run of Fs bits (`fbit_ft_i`=0). Bits of the other type are ignored in each phase, even when errored.
- R5: In D4 mode with `sync_crit_i`=1, Ft and Fs bits count together, and an error on either type restarts qualification.
- R6: In ESF mode, `fbit_ft_i` is ignored. With `sync_crit_i`=0, sync follows the run alone. With `sync_crit_i`=1, after the run the block waits for `crc_valid_i`. `crc_ok_i`=1 declares sync; `crc_ok_i`=0 pulses `search_req_o` and restarts.
- R7: In sync, out-of-frame is declared when at least 2 of the most recent N framing bits are errored. N=4 when {`oof_sel2_i`,`oof_sel1_i`}=00, N=5 when it is 01, and N=6 whenever `oof_sel2_i`=1. The error history is emptied when sync is declared.
- R8: With `auto_dis_i`=0, an out-of-frame event clears `in_sync_o` and pulses `search_req_o` on the clock after the offending bit.
- R9: With `auto_dis_i`=0 and `auto_crit_i`=0, `carrier_loss_i` high while in sync also starts a resync. With `auto_crit_i`=1, carrier loss is ignored.
- R10: With `auto_dis_i`=1, out-of-frame clears `in_sync_o` but issues no request. The block then stays out of sync, ignoring framing bits and carrier loss, until a manual resync.
- R11: A 0-to-1 transition of `resync_i` starts a resync from any state: one `search_req_o` pulse and a fresh qualification. Holding `resync_i` high triggers nothing further.
- R12: Coinciding resync causes (manual edge, out-of-frame, carrier loss) in one clock produce a single one-clock request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| esf_mode_i | input | 1 | 1 = ESF, 0 = D4 |
| oof_sel1_i | input | 1 | Window select low bit (4 or 5) |
| oof_sel2_i | input | 1 | Forces a 6-bit window |
| sync_crit_i | input | 1 | D4: cross-couple Ft/Fs; ESF: require CRC6 confirm |
| sync_long_i | input | 1 | Qualification length 24 instead of 10 |
| auto_crit_i | input | 1 | 1 = only out-of-frame triggers auto resync |
| auto_dis_i | input | 1 | 1 = automatic resync disabled |
| resync_i | input | 1 | Manual resync, rising-edge active |
| fbit_valid_i | input | 1 | One framing-bit result this clock |
| fbit_err_i | input | 1 | Framing bit mismatched |
| fbit_ft_i | input | 1 | D4 bit type: 1 = Ft, 0 = Fs |
| carrier_loss_i | input | 1 | Receive carrier loss |
| crc_valid_i | input | 1 | CRC6 result available |
| crc_ok_i | input | 1 | CRC6 result passed |
| in_sync_o | output | 1 | Frame sync declared |
| search_req_o | output | 1 | One-clock pulse: begin a new alignment search |

## Verification
The out-of-frame decision and the manual resync edge can fall in the same clock. So can out-of-frame and carrier loss. The bench provokes each pairing by presenting the window's second error in the clock where `resync_i` rises or `carrier_loss_i` goes high. It then counts request cycles over the following clocks and expects exactly one, with `in_sync_o` low and qualification restarted. Separately, the bench sweeps all 64 six-bit error patterns under every window setting. A bench-side sliding count gives the exact bit at which sync must drop.

// File: rtl/t1_sync_pkg.sv
package t1_sync_pkg;
  typedef enum logic [1:0] {
    ST_QUAL = 2'd0,
    ST_SYNC = 2'd1,
    ST_HOLD = 2'd2
  } sup_state_e;
endpackage

// File: rtl/t1_resync_trigger.sv
module t1_resync_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic resync_i,
  output logic rise_o
);
  logic resync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) resync_q <= 1'b0;
    else         resync_q <= resync_i;
  end

  assign rise_o = resync_i & ~resync_q;

  // R11: a held level never yields two consecutive triggers
  a_r11_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/t1_oof_window.sv
module t1_oof_window #(
  parameter int WIN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic bit_valid_i,
  input  logic bit_err_i,
  input  logic sel1_i,
  input  logic sel2_i,
  output logic oof_hit_o
);
  localparam int ONES_W = $clog2(WIN + 1);

  logic [WIN-1:0]    win_q, win_nx, mask;
  logic [ONES_W-1:0] ones;
  int                depth;

  assign win_nx = {win_q[WIN-2:0], bit_err_i};

  always_comb begin
    depth = sel2_i ? WIN : (sel1_i ? WIN - 1 : WIN - 2);
    ones  = '0;
    for (int i = 0; i < WIN; i++) begin
      mask[i] = (i < depth);
      ones    = ones + ONES_W'(win_nx[i] & mask[i]);
    end
  end

  assign oof_hit_o = bit_valid_i && (ones >= ONES_W'(2));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          win_q <= '0;
    else if (clear_i)     win_q <= '0;
    else if (bit_valid_i) win_q <= win_nx;
  end

  // R7: an emptied history cannot reach two errors on the next bit
  a_r7_empty_after_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !oof_hit_o);
endmodule

// File: rtl/t1_sync_qualifier.sv
module t1_sync_qualifier #(
  parameter int QUAL_SHORT = 10,
  parameter int QUAL_LONG  = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic active_i,
  input  logic bit_valid_i,
  input  logic bit_err_i,
  input  logic bit_ft_i,
  input  logic esf_i,
  input  logic crit_i,
  input  logic long_i,
  input  logic crc_valid_i,
  input  logic crc_ok_i,
  output logic done_o,
  output logic fail_o
);
  localparam int CNT_W = $clog2(QUAL_LONG + 1);

  logic [CNT_W-1:0] cnt_q, cnt_inc, target;
  logic phase_q, crc_wait_q;
  logic relevant, take, hit_end, seq_step, need_crc, crc_res;

  assign target  = long_i ? CNT_W'(QUAL_LONG) : CNT_W'(QUAL_SHORT);
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    // sequential D4: phase 0 counts Ft, phase 1 counts Fs
    relevant = esf_i || crit_i || (phase_q ? !bit_ft_i : bit_ft_i);
    take     = active_i && bit_valid_i && relevant && !crc_wait_q;
    hit_end  = take && !bit_err_i && (cnt_inc == target);
    seq_step = hit_end && !esf_i && !crit_i && !phase_q;
    need_crc = hit_end && esf_i && crit_i;
    crc_res  = active_i && crc_wait_q && crc_valid_i;
    done_o   = (hit_end && !seq_step && !need_crc) || (crc_res && crc_ok_i);
    fail_o   = (take && bit_err_i) || (crc_res && !crc_ok_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; phase_q <= 1'b0; crc_wait_q <= 1'b0;
    end else if (clear_i || done_o || fail_o) begin
      cnt_q <= '0; phase_q <= 1'b0; crc_wait_q <= 1'b0;
    end else if (seq_step) begin
      cnt_q <= '0; phase_q <= 1'b1;
    end else if (need_crc) begin
      crc_wait_q <= 1'b1;
    end else if (take && !bit_err_i) begin
      cnt_q <= cnt_inc;
    end
  end

  // R3/R6: a single clock never both declares and rejects
  a_r6_done_fail_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));
  // R2: count never passes the selected run length
  a_r2_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(QUAL_LONG));
endmodule

// File: rtl/t1_sync_supervisor.sv
module t1_sync_supervisor
  import t1_sync_pkg::*;
#(
  parameter int QUAL_SHORT = 10,
  parameter int QUAL_LONG  = 24,
  parameter int WIN        = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic esf_mode_i,
  input  logic oof_sel1_i,
  input  logic oof_sel2_i,
  input  logic sync_crit_i,
  input  logic sync_long_i,
  input  logic auto_crit_i,
  input  logic auto_dis_i,
  input  logic resync_i,
  input  logic fbit_valid_i,
  input  logic fbit_err_i,
  input  logic fbit_ft_i,
  input  logic carrier_loss_i,
  input  logic crc_valid_i,
  input  logic crc_ok_i,
  output logic in_sync_o,
  output logic search_req_o
);
  sup_state_e state_q, st_nx;
  logic man_rise, oof_hit, q_done, q_fail, q_clear, req_nx;

  t1_resync_trigger u_trig (
    .clk_i, .rst_ni, .resync_i, .rise_o(man_rise)
  );

  t1_oof_window #(.WIN(WIN)) u_win (
    .clk_i, .rst_ni,
    .clear_i    (q_done),
    .bit_valid_i(fbit_valid_i && state_q == ST_SYNC),
    .bit_err_i  (fbit_err_i),
    .sel1_i     (oof_sel1_i),
    .sel2_i     (oof_sel2_i),
    .oof_hit_o  (oof_hit)
  );

  t1_sync_qualifier #(.QUAL_SHORT(QUAL_SHORT), .QUAL_LONG(QUAL_LONG)) u_qual (
    .clk_i, .rst_ni,
    .clear_i    (q_clear),
    .active_i   (state_q == ST_QUAL),
    .bit_valid_i(fbit_valid_i),
    .bit_err_i  (fbit_err_i),
    .bit_ft_i   (fbit_ft_i),
    .esf_i      (esf_mode_i),
    .crit_i     (sync_crit_i),
    .long_i     (sync_long_i),
    .crc_valid_i,
    .crc_ok_i,
    .done_o     (q_done),
    .fail_o     (q_fail)
  );

  always_comb begin
    st_nx   = state_q;
    req_nx  = 1'b0;
    q_clear = 1'b0;
    if (man_rise) begin
      st_nx = ST_QUAL; req_nx = 1'b1; q_clear = 1'b1;
    end else begin
      unique case (state_q)
        ST_SYNC: begin
          if (oof_hit) begin
            if (!auto_dis_i) begin
              st_nx = ST_QUAL; req_nx = 1'b1; q_clear = 1'b1;
            end else begin
              st_nx = ST_HOLD;
            end
          end else if (carrier_loss_i && !auto_crit_i && !auto_dis_i) begin
            st_nx = ST_QUAL; req_nx = 1'b1; q_clear = 1'b1;
          end
        end
        ST_QUAL: begin
          if (q_done)      st_nx = ST_SYNC;
          else if (q_fail) req_nx = 1'b1;
        end
        default: st_nx = state_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_QUAL;
      search_req_o <= 1'b0;
    end else begin
      state_q      <= st_nx;
      search_req_o <= req_nx;
    end
  end

  assign in_sync_o = (state_q == ST_SYNC);

  // R8: automatic resync on out-of-frame
  a_r8_auto_resync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC && oof_hit && !auto_dis_i) |=> (search_req_o && !in_sync_o));
  // R10: holding state issues no requests
  a_r10_hold_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HOLD && $past(state_q == ST_HOLD)) |-> !search_req_o);
  // R11: manual edge always requests a search
  a_r11_rise_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    man_rise |=> (search_req_o && !in_sync_o));
  // R2: sync is only entered from qualification
  a_r2_sync_from_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_sync_o) |-> $past(state_q == ST_QUAL));
endmodule

// File: tb/t1_sync_supervisor_tb.sv
module t1_sync_supervisor_tb;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic esf_mode_i = 0, oof_sel1_i = 0, oof_sel2_i = 0, sync_crit_i = 1;
  logic sync_long_i = 0, auto_crit_i = 0, auto_dis_i = 0, resync_i = 0;
  logic fbit_valid_i = 0, fbit_err_i = 0, fbit_ft_i = 0, carrier_loss_i = 0;
  logic crc_valid_i = 0, crc_ok_i = 0;
  logic in_sync_o, search_req_o;

  int n_tests = 0, n_fail = 0;

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  t1_sync_supervisor u_dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic send_bit(input logic err, input logic ft);
    fbit_valid_i = 1; fbit_err_i = err; fbit_ft_i = ft;
    step();
    fbit_valid_i = 0; fbit_err_i = 0;
  endtask

  task automatic good_run(input int n, input logic ft);
    for (int i = 0; i < n; i++) send_bit(1'b0, ft);
  endtask

  // rising edge on resync_i; request must follow one clock later
  task automatic manual(input string tag);
    resync_i = 1; step();
    chk(tag, search_req_o, 1'b1);
    chk(tag, in_sync_o, 1'b0);
    resync_i = 0; step();
    chk(tag, search_req_o, 1'b0);
  endtask

  task automatic qualify();
    for (int i = 0; i < 10; i++) send_bit(1'b0, i[0]);
  endtask

  initial begin : main
    int req_cnt;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    chk("R1", in_sync_o, 1'b0);
    chk("R1", search_req_o, 1'b0);
    step();
    chk("R1", in_sync_o, 1'b0);

    // R2 short and long qualification, cross-coupled D4
    good_run(9, 1'b1);
    chk("R2", in_sync_o, 1'b0);
    send_bit(1'b0, 1'b0);
    chk("R2", in_sync_o, 1'b1);
    chk("R2", search_req_o, 1'b0);
    manual("R11");
    sync_long_i = 1;
    good_run(23, 1'b0);
    chk("R2", in_sync_o, 1'b0);
    send_bit(1'b0, 1'b1);
    chk("R2", in_sync_o, 1'b1);
    sync_long_i = 0;
    manual("R11");

    // R3 / R5: error restarts count, Fs error counts when cross-coupled
    good_run(5, 1'b1);
    send_bit(1'b1, 1'b0);
    chk("R3", search_req_o, 1'b1);
    chk("R5", in_sync_o, 1'b0);
    step();
    chk("R3", search_req_o, 1'b0);
    good_run(9, 1'b1);
    chk("R3", in_sync_o, 1'b0);
    send_bit(1'b0, 1'b1);
    chk("R3", in_sync_o, 1'b1);
    manual("R11");

    // R4: sequential Ft then Fs
    sync_crit_i = 0;
    send_bit(1'b1, 1'b0);
    chk("R4", search_req_o, 1'b0);
    good_run(10, 1'b1);
    chk("R4", in_sync_o, 1'b0);
    send_bit(1'b1, 1'b1);
    chk("R4", search_req_o, 1'b0);
    good_run(9, 1'b0);
    chk("R4", in_sync_o, 1'b0);
    send_bit(1'b0, 1'b0);
    chk("R4", in_sync_o, 1'b1);
    manual("R11");

    // R6: ESF, without and with CRC confirmation
    esf_mode_i = 1;
    good_run(10, 1'b0);
    chk("R6", in_sync_o, 1'b1);
    manual("R11");
    sync_crit_i = 1;
    good_run(10, 1'b0);
    chk("R6", in_sync_o, 1'b0);
    crc_valid_i = 1; crc_ok_i = 0; step(); crc_valid_i = 0;
    chk("R6", search_req_o, 1'b1);
    chk("R6", in_sync_o, 1'b0);
    good_run(10, 1'b1);
    chk("R6", in_sync_o, 1'b0);
    crc_valid_i = 1; crc_ok_i = 1; step(); crc_valid_i = 0;
    chk("R6", in_sync_o, 1'b1);
    chk("R6", search_req_o, 1'b0);
    esf_mode_i = 0;
    manual("R11");

    // R9: carrier loss policy
    qualify();
    carrier_loss_i = 1; step();
    chk("R9", in_sync_o, 1'b0);
    chk("R9", search_req_o, 1'b1);
    carrier_loss_i = 0; step();
    qualify();
    auto_crit_i = 1; carrier_loss_i = 1;
    repeat (3) step();
    chk("R9", in_sync_o, 1'b1);
    chk("R9", search_req_o, 1'b0);
    carrier_loss_i = 0; auto_crit_i = 0;

    // R10: auto resync disabled
    auto_dis_i = 1;
    carrier_loss_i = 1; step(); carrier_loss_i = 0;
    chk("R10", in_sync_o, 1'b1);
    send_bit(1'b1, 1'b0);
    send_bit(1'b1, 1'b1);
    chk("R10", in_sync_o, 1'b0);
    chk("R10", search_req_o, 1'b0);
    for (int i = 0; i < 12; i++) begin
      send_bit(1'b0, i[0]);
      chk("R10", in_sync_o, 1'b0);
      chk("R10", search_req_o, 1'b0);
    end
    auto_dis_i = 0;
    manual("R10");
    qualify();
    chk("R10", in_sync_o, 1'b1);

    // R11: held level does not retrigger
    resync_i = 1; step();
    chk("R11", search_req_o, 1'b1);
    for (int i = 0; i < 10; i++) begin
      send_bit(1'b0, i[0]);
      chk("R11", search_req_o, 1'b0);
    end
    chk("R11", in_sync_o, 1'b1);
    resync_i = 0; step();
    manual("R11");
    qualify();

    // R12: out-of-frame coincides with manual edge, then with carrier loss
    send_bit(1'b1, 1'b0);
    chk("R12", in_sync_o, 1'b1);
    resync_i = 1;
    send_bit(1'b1, 1'b1);
    req_cnt = int'(search_req_o);
    chk("R12", in_sync_o, 1'b0);
    for (int i = 0; i < 4; i++) begin step(); req_cnt += int'(search_req_o); end
    chk("R12", req_cnt == 1, 1'b1);
    resync_i = 0; step();
    qualify();
    send_bit(1'b1, 1'b0);
    carrier_loss_i = 1;
    send_bit(1'b1, 1'b0);
    req_cnt = int'(search_req_o);
    chk("R12", in_sync_o, 1'b0);
    for (int i = 0; i < 4; i++) begin step(); req_cnt += int'(search_req_o); end
    chk("R12", req_cnt == 1, 1'b1);
    carrier_loss_i = 0; step();

    // R7 / R8: every 6-bit error pattern under every window select
    for (int sel = 0; sel < 4; sel++) begin
      oof_sel1_i = sel[0]; oof_sel2_i = sel[1];
      for (int pat = 0; pat < 64; pat++) begin
        int w;
        logic dropped;
        w = oof_sel2_i ? 6 : (oof_sel1_i ? 5 : 4);
        manual("R8");
        qualify();
        chk("R7", in_sync_o, 1'b1);
        dropped = 0;
        for (int k = 0; k < 6 && !dropped; k++) begin
          int errs;
          send_bit(pat[k], k[0]);
          errs = 0;
          for (int j = 0; j <= k; j++) if (j > k - w && pat[j]) errs++;
          dropped = (errs >= 2);
          chk("R7", in_sync_o, !dropped);
          chk("R8", search_req_o, dropped);
        end
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule